// File: doc/BRIEF.md
# Two-Tier Level and Priority Interrupt Controller

This block gathers ten internal interrupt sources and one external request, encoded on four pins. It picks the single request that should interrupt the processor and presents that request's level on a registered three-bit output. Each internal source has an 8-bit control byte that holds four settings:

- a three-bit level;
- a two-bit rank within that level;
- a bit that selects an automatic vector;
- two reserved bits that always read as zero.

Arbitration has two tiers. The highest level wins first. Within that level, five slots are ordered as internal rank 3, internal rank 2, the external request, internal rank 1 and internal rank 0. When the processor starts an acknowledge, the block freezes the winner. It then reports which source was acknowledged, at which level, and whether the controller or the source supplies the vector. When the controller supplies it, the block also drives the vector number itself.

Software reaches the control bytes through a small byte-wide read/write port at ten consecutive offsets.

Top module: `lic_top`

## Requirements
- R1: After reset, every control byte reads 0x00, `ipl_o` is 0 and `ack_valid_o` is 0.
- R2: Source i's control byte is at offset 0x4C+i, for i from 0 to 9. The byte holds the autovector bit at bit 7, the level at bits 4:2 and the rank at bits 1:0. Bits 6:5 always read 0, whatever is written. A write to an offset outside 0x4C..0x55 changes nothing, and a read there returns 0.
- R3: A source whose level field is 0 never requests. With no request pending, `ipl_o` is 0, and an acknowledge reports level 0 and source code 15.
- R4: Among the pending requests, the one with the highest level wins.
- R5: Within one level, a higher rank field wins. The encodings rank from 11 (highest) through 10 and 01 down to 00 (lowest).
- R6: The external level is 7 when pin 3 is high. Otherwise it is the binary value of pins 2:0, and 0 means no request. Within a level, the external request ranks below an internal rank 10 and above an internal rank 01. Its source code is 10.
- R7: When two internal sources have the same level and the same rank, the lower source index wins.
- R8: `ipl_o` is registered. It shows the winner of the inputs seen at the previous rising clock edge.
- R9: The first edge with `iack_i` high captures the winner. From the next cycle on, and for as long as `iack_i` stays high, `ack_valid_o` is 1, the acknowledge outputs hold the captured source and level, and `ipl_o` holds the same level. The controller resumes tracking the winner once `iack_i` drops.
- R10: If the acknowledged source's autovector selection is 1, `ack_autovec_o` is 1 and `ack_vec_o` equals 24 plus the level. For an internal source this selection is bit 7 of its control byte; for the external request it is `ext_autovec_i`. Otherwise both `ack_autovec_o` and `ack_vec_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Byte offset for the control-byte port |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| src_req_i | input | 10 | Internal request lines, bit i is source i |
| ext_pin_i | input | 4 | External request pins |
| ext_autovec_i | input | 1 | Autovector selection for the external request |
| iack_i | input | 1 | Acknowledge cycle in progress |
| ipl_o | output | 3 | Registered winning level |
| ack_valid_o | output | 1 | Acknowledge result valid |
| ack_lvl_o | output | 3 | Acknowledged level |
| ack_src_o | output | 4 | Acknowledged source: 0..9 internal, 10 external, 15 none |
| ack_autovec_o | output | 1 | Controller supplies the vector |
| ack_vec_o | output | 8 | Autovector number, or 0 |

## Verification
Request mixes are chosen so that each one separates exactly one arbitration rule:

- Sources on different levels test the level comparison.
- Sources that share a level but differ in rank test the rank order.
- An exact tie in level and rank checks that the lower index wins.
- The external request, placed against internal ranks 10, 01 and 00 at the same level, fixes its slot between them.

A masked source alone shows that level 0 produces no request. An acknowledge held while the requests change shows that the captured winner, and its vector decision, do not follow the inputs until the acknowledge ends.

// File: rtl/lic_pkg.sv
package lic_pkg;

  typedef struct packed {
    logic       avec;
    logic [2:0] lvl;
    logic [1:0] pri;
  } icr_t;

  localparam logic [2:0] EXT_SLOT = 3'd2;

  // map a 2-bit rank into the 5-slot order, leaving slot 2 for the external pin
  function automatic logic [2:0] slot_of(input logic [1:0] pri);
    logic [2:0] s;
    case (pri)
      2'b11:   s = 3'd4;
      2'b10:   s = 3'd3;
      2'b01:   s = 3'd1;
      default: s = 3'd0;
    endcase
    return s;
  endfunction

  function automatic icr_t pack_icr(input logic [7:0] b);
    icr_t r;
    r.avec = b[7];
    r.lvl  = b[4:2];
    r.pri  = b[1:0];
    return r;
  endfunction

  function automatic logic [7:0] unpack_icr(input icr_t r);
    return {r.avec, 2'b00, r.lvl, r.pri};
  endfunction

endpackage

// File: rtl/lic_regs.sv
module lic_regs
  import lic_pkg::*;
#(
  parameter int N_SRC = 10,
  parameter int AW    = 8,
  parameter int BASE  = 'h4C
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          addr_i,
  input  logic                   wr_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  output icr_t [N_SRC-1:0]       icr_o
);

  logic [AW-1:0] off;
  logic          hit;
  icr_t [N_SRC-1:0] icr_d, icr_q;

  assign off = addr_i - AW'(BASE);
  assign hit = (addr_i >= AW'(BASE)) && (off < AW'(N_SRC));

  for (genvar g = 0; g < N_SRC; g++) begin : g_reg
    logic sel;
    assign sel = wr_i && hit && (off == AW'(g));

    always_comb begin
      icr_d[g] = icr_q[g];
      if (sel) icr_d[g] = pack_icr(wdata_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) icr_q[g] <= '0;
      else if (sel) icr_q[g] <= icr_d[g];
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < N_SRC; i++) begin
      if (hit && off == AW'(i)) rdata_o = unpack_icr(icr_q[i]);
    end
  end

  assign icr_o = icr_q;

endmodule

// File: rtl/lic_arb.sv
module lic_arb
  import lic_pkg::*;
#(
  parameter int N_SRC = 10,
  parameter int IDW   = 4
) (
  input  icr_t [N_SRC-1:0] icr_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic [2:0]       ext_lvl_i,
  input  logic             ext_avec_i,
  output logic [2:0]       win_lvl_o,
  output logic [IDW-1:0]   win_id_o,
  output logic             win_avec_o
);

  localparam logic [IDW-1:0] ID_EXT  = IDW'(N_SRC);
  localparam logic [IDW-1:0] ID_NONE = '1;

  logic [N_SRC-1:0][5:0] key;
  logic [5:0]            ext_key;

  for (genvar g = 0; g < N_SRC; g++) begin : g_key
    assign key[g] = (req_i[g] && icr_i[g].lvl != 3'd0)
                  ? {icr_i[g].lvl, slot_of(icr_i[g].pri)} : 6'd0;
  end

  assign ext_key = (ext_lvl_i != 3'd0) ? {ext_lvl_i, EXT_SLOT} : 6'd0;

  always_comb begin
    logic [5:0] best;
    best       = 6'd0;
    win_id_o   = ID_NONE;
    win_avec_o = 1'b0;
    // strict compare from index 0 upward keeps the lower index on a tie
    for (int i = 0; i < N_SRC; i++) begin
      if (key[i] > best) begin
        best       = key[i];
        win_id_o   = IDW'(i);
        win_avec_o = icr_i[i].avec;
      end
    end
    if (ext_key > best) begin
      best       = ext_key;
      win_id_o   = ID_EXT;
      win_avec_o = ext_avec_i;
    end
    win_lvl_o = best[5:3];
  end

endmodule

// File: rtl/lic_ack.sv
module lic_ack #(
  parameter int IDW       = 4,
  parameter int VW        = 8,
  parameter int AVEC_BASE = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iack_i,
  input  logic [2:0]     win_lvl_i,
  input  logic [IDW-1:0] win_id_i,
  input  logic           win_avec_i,
  output logic [2:0]     ipl_o,
  output logic           ack_valid_o,
  output logic [2:0]     ack_lvl_o,
  output logic [IDW-1:0] ack_src_o,
  output logic           ack_autovec_o,
  output logic [VW-1:0]  ack_vec_o
);

  logic           frz_q, frz_d;
  logic           cap, upd;
  logic [2:0]     ipl_q, ipl_d;
  logic [2:0]     lvl_q, lvl_d;
  logic [IDW-1:0] src_q, src_d;
  logic           av_q, av_d;
  logic [VW-1:0]  vec_q, vec_d;

  assign cap = iack_i & ~frz_q;
  assign upd = ~frz_q;

  always_comb begin
    frz_d = iack_i;
    ipl_d = upd ? win_lvl_i : ipl_q;
    lvl_d = lvl_q;
    src_d = src_q;
    av_d  = av_q;
    vec_d = vec_q;
    if (cap) begin
      lvl_d = win_lvl_i;
      src_d = win_id_i;
      av_d  = win_avec_i;
      vec_d = win_avec_i ? (VW'(AVEC_BASE) + VW'(win_lvl_i)) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q <= 1'b0;
      ipl_q <= '0;
      lvl_q <= '0;
      src_q <= '0;
      av_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      frz_q <= frz_d;
      if (upd) ipl_q <= ipl_d;
      if (cap) begin
        lvl_q <= lvl_d;
        src_q <= src_d;
        av_q  <= av_d;
        vec_q <= vec_d;
      end
    end
  end

  assign ipl_o         = ipl_q;
  assign ack_valid_o   = frz_q;
  assign ack_lvl_o     = lvl_q;
  assign ack_src_o     = src_q;
  assign ack_autovec_o = av_q;
  assign ack_vec_o     = vec_q;

endmodule

// File: rtl/lic_top.sv
module lic_top
  import lic_pkg::*;
#(
  parameter int N_SRC     = 10,
  parameter int AW        = 8,
  parameter int BASE      = 'h4C,
  parameter int VW        = 8,
  parameter int AVEC_BASE = 24,
  localparam int IDW      = $clog2(N_SRC + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic [3:0]       ext_pin_i,
  input  logic             ext_autovec_i,
  input  logic             iack_i,
  output logic [2:0]       ipl_o,
  output logic             ack_valid_o,
  output logic [2:0]       ack_lvl_o,
  output logic [IDW-1:0]   ack_src_o,
  output logic             ack_autovec_o,
  output logic [VW-1:0]    ack_vec_o
);

  icr_t [N_SRC-1:0] icr;
  logic [2:0]       ext_lvl;
  logic [2:0]       win_lvl;
  logic [IDW-1:0]   win_id;
  logic             win_avec;

  // pin 3 forces the top level, otherwise pins 2:0 carry the level in binary
  always_comb begin
    if (ext_pin_i[3]) ext_lvl = 3'd7;
    else              ext_lvl = ext_pin_i[2:0];
  end

  lic_regs #(.N_SRC(N_SRC), .AW(AW), .BASE(BASE)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (reg_addr_i),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .icr_o   (icr)
  );

  lic_arb #(.N_SRC(N_SRC), .IDW(IDW)) u_arb (
    .icr_i      (icr),
    .req_i      (src_req_i),
    .ext_lvl_i  (ext_lvl),
    .ext_avec_i (ext_autovec_i),
    .win_lvl_o  (win_lvl),
    .win_id_o   (win_id),
    .win_avec_o (win_avec)
  );

  lic_ack #(.IDW(IDW), .VW(VW), .AVEC_BASE(AVEC_BASE)) u_ack (
    .clk           (clk),
    .rst_n         (rst_n),
    .iack_i        (iack_i),
    .win_lvl_i     (win_lvl),
    .win_id_i      (win_id),
    .win_avec_i    (win_avec),
    .ipl_o         (ipl_o),
    .ack_valid_o   (ack_valid_o),
    .ack_lvl_o     (ack_lvl_o),
    .ack_src_o     (ack_src_o),
    .ack_autovec_o (ack_autovec_o),
    .ack_vec_o     (ack_vec_o)
  );

endmodule

// File: rtl/lic_chk.sv
module lic_chk #(
  parameter int IDW       = 4,
  parameter int VW        = 8,
  parameter int AVEC_BASE = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           iack_i,
  input logic [7:0]     reg_rdata_o,
  input logic [2:0]     ipl_o,
  input logic           ack_valid_o,
  input logic [2:0]     ack_lvl_o,
  input logic [IDW-1:0] ack_src_o,
  input logic           ack_autovec_o,
  input logic [VW-1:0]  ack_vec_o
);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[6:5] == 2'b00);

  p_none_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && ack_lvl_o == 3'd0) |-> ack_src_o == '1);

  p_ack_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack_i) |=> ack_valid_o);

  p_ipl_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> ipl_o == ack_lvl_o);

  p_ack_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && iack_i) |=> ($stable(ack_src_o) && $stable(ack_lvl_o)
                                 && $stable(ack_autovec_o) && $stable(ipl_o)));

  p_avec_num_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && ack_autovec_o) |-> ack_vec_o == VW'(AVEC_BASE) + VW'(ack_lvl_o));

  p_src_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && !ack_autovec_o) |-> ack_vec_o == '0);

endmodule

bind lic_top lic_chk #(.IDW(IDW), .VW(VW), .AVEC_BASE(AVEC_BASE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .iack_i        (iack_i),
  .reg_rdata_o   (reg_rdata_o),
  .ipl_o         (ipl_o),
  .ack_valid_o   (ack_valid_o),
  .ack_lvl_o     (ack_lvl_o),
  .ack_src_o     (ack_src_o),
  .ack_autovec_o (ack_autovec_o),
  .ack_vec_o     (ack_vec_o)
);

// File: tb/lic_top_tb.sv
module lic_top_tb;

  localparam int EXT  = 10;
  localparam int NONE = 15;

  logic       clk;
  logic       rst_n;
  logic [7:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [9:0] src_req;
  logic [3:0] ext_pin;
  logic       ext_av;
  logic       iack;
  logic [2:0] ipl;
  logic       ack_valid;
  logic [2:0] ack_lvl;
  logic [3:0] ack_src;
  logic       ack_av;
  logic [7:0] ack_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    int    id;
    int    lvl;
    int    av;
    int    vec;
    string tag;
  } exp_t;

  exp_t sbq[$];

  lic_top u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr_i    (reg_addr),
    .reg_wr_i      (reg_wr),
    .reg_wdata_i   (reg_wdata),
    .reg_rdata_o   (reg_rdata),
    .src_req_i     (src_req),
    .ext_pin_i     (ext_pin),
    .ext_autovec_i (ext_av),
    .iack_i        (iack),
    .ipl_o         (ipl),
    .ack_valid_o   (ack_valid),
    .ack_lvl_o     (ack_lvl),
    .ack_src_o     (ack_src),
    .ack_autovec_o (ack_av),
    .ack_vec_o     (ack_vec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: pop one expected item on each new acknowledge result
  bit prev_valid = 0;
  always @(negedge clk) begin
    if (rst_n && ack_valid && !prev_valid) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: unexpected ack src %0d lvl %0d, expected none", ack_src, ack_lvl);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk({e.tag, " ack src"}, int'(ack_src), e.id);
        chk({e.tag, " ack lvl"}, int'(ack_lvl), e.lvl);
        chk({e.tag, " ack autovec"}, int'(ack_av), e.av);
        chk({e.tag, " ack vec"}, int'(ack_vec), e.vec);
      end
    end
    prev_valid <= ack_valid;
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 8'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, input int a, input int exp);
    reg_addr = 8'(a);
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic apply(input int req, input int pins, input int av, input int exp_lvl, string tag);
    @(negedge clk);
    src_req = 10'(req); ext_pin = 4'(pins); ext_av = av[0];
    @(negedge clk);
    chk({tag, " ipl"}, int'(ipl), exp_lvl);
  endtask

  // driver: push expectation, then run one acknowledge
  task automatic do_ack(input int id, input int lvl, input int av, input int vec, string tag);
    exp_t e;
    e.id = id; e.lvl = lvl; e.av = av; e.vec = vec; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk); iack = 1'b1;
    @(negedge clk);
    @(negedge clk); iack = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    src_req = '0; ext_pin = '0; ext_av = 1'b0; iack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 10; i++) rd_chk("R1 reset byte", 'h4C + i, 0);
    chk("R1 reset ipl", int'(ipl), 0);
    chk("R1 reset ack_valid", int'(ack_valid), 0);

    // R2 layout, reserved bits, out-of-range
    wr('h55, 'hFF);
    rd_chk("R2 reserved bits read zero", 'h55, 'h9F);
    wr('h56, 'hFF);
    wr('h4B, 'hFF);
    rd_chk("R2 out-of-range read 0x56", 'h56, 0);
    rd_chk("R2 out-of-range read 0x4B", 'h4B, 0);
    rd_chk("R2 neighbour 0x54 untouched", 'h54, 0);
    rd_chk("R2 neighbour 0x4C untouched", 'h4C, 0);

    wr('h4C, 'h8D); // src0 lvl3 pri01 av1
    wr('h4D, 'h14); // src1 lvl5 pri00
    wr('h4E, 'h17); // src2 lvl5 pri11
    wr('h4F, 'h03); // src3 lvl0 masked
    wr('h50, 'h97); // src4 lvl5 pri11 av1
    wr('h51, 'h9E); // src5 lvl7 pri10 av1
    wr('h52, 'h16); // src6 lvl5 pri10
    wr('h53, 'h15); // src7 lvl5 pri01
    rd_chk("R2 readback src0", 'h4C, 'h8D);
    rd_chk("R2 readback src5", 'h51, 'h9E);

    // R3 masked source
    apply(10'b0000001000, 0, 0, 0, "R3 masked");
    do_ack(NONE, 0, 0, 0, "R3 masked");

    // R4 level wins
    apply(10'b0000000011, 0, 0, 5, "R4 level");
    do_ack(1, 5, 0, 0, "R4 level");

    // R5 rank within level
    apply(10'b0000000110, 0, 0, 5, "R5 rank");
    do_ack(2, 5, 0, 0, "R5 rank");

    // R7 tie resolved to lower index
    apply(10'b0000010100, 0, 0, 5, "R7 tie");
    do_ack(2, 5, 0, 0, "R7 tie");

    // R10 autovector from control byte
    apply(10'b0000010000, 0, 0, 5, "R10 autovec");
    do_ack(4, 5, 1, 29, "R10 autovec");

    // R6 external slot
    apply(10'b0010000010, 'b0101, 1, 5, "R6 ext over 01/00");
    do_ack(EXT, 5, 1, 29, "R6 ext over 01/00");
    apply(10'b0001000000, 'b0101, 1, 5, "R6 rank10 over ext");
    do_ack(6, 5, 0, 0, "R6 rank10 over ext");
    apply(10'b0000000100, 'b0101, 1, 5, "R6 rank11 over ext");
    do_ack(2, 5, 0, 0, "R6 rank11 over ext");
    apply(10'b0000100000, 'b0101, 1, 7, "R6 higher level over ext");
    do_ack(5, 7, 1, 31, "R6 higher level over ext");
    apply(0, 'b1000, 0, 7, "R6 pin3 level7");
    do_ack(EXT, 7, 0, 0, "R6 pin3 level7");
    apply(0, 'b1011, 1, 7, "R6 pin3 overrides low pins");
    apply(0, 'b0011, 1, 3, "R6 binary level 3");
    do_ack(EXT, 3, 1, 27, "R6 binary level 3");

    // R8 registered output
    apply(0, 0, 0, 0, "R8 idle");
    @(negedge clk);
    src_req = 10'b0000100000;
    #1;
    chk("R8 ipl not yet updated", int'(ipl), 0);
    @(negedge clk);
    chk("R8 ipl after one edge", int'(ipl), 7);

    // R9 freeze during acknowledge
    apply(10'b0000010000, 0, 0, 5, "R9 setup");
    begin
      exp_t e;
      e.id = 4; e.lvl = 5; e.av = 1; e.vec = 29; e.tag = "R9 freeze";
      sbq.push_back(e);
    end
    @(negedge clk); iack = 1'b1;
    @(negedge clk); src_req = 10'b0000100000;
    @(negedge clk);
    chk("R9 ipl held", int'(ipl), 5);
    chk("R9 src held", int'(ack_src), 4);
    chk("R9 valid held", int'(ack_valid), 1);
    iack = 1'b0;
    @(negedge clk);
    chk("R9 valid cleared", int'(ack_valid), 0);
    @(negedge clk);
    chk("R9 ipl resumes", int'(ipl), 7);

    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", sbq.size(), 0);
    summary();
  end

endmodule